// File: doc/BRIEF.md
# Low-Power Mode Controller

This block moves a processor subsystem between a running state and two power-save states. A single power-save request, qualified by a one-bit mode operand, selects either Idle, where only the CPU clock is stopped, or Sleep, where the system clock source itself is turned off. The block drives clock-gate enables for the CPU, for the peripherals that need the system clock and for the main oscillator. It also drives enables for the low-power RC clock and the fail-safe clock monitor, and a one-cycle clear pulse for the watchdog counter.

In both power-save states a wake condition returns the subsystem to Run. A wake condition is an interrupt line that is both pending and enabled, or a watchdog time-out. Leaving Sleep first restarts the oscillator and waits for its ready indication, which is modelled as an input. The block owns the system clock selection register. It blocks writes to it outside Run, snapshots it on the way into Sleep and reloads that snapshot on wake. An asynchronous reset overrides everything and returns the block to Run with the reset clock selection. Two status flags show whether the most recent return to Run came from Sleep or from Idle.

Top module: `lpm_ctrl`

## Requirements
- R1: The state code `pwr_state` uses 0 for Run, 1 for Idle, 2 for sleep entry, 3 for Sleep, 4 for oscillator restart and 5 for wake sync. A `pwr_req` pulse is sampled at a rising edge only in Run. `pwr_mode`=0 moves the block to Idle and `pwr_mode`=1 moves it to sleep entry at that same edge. A request in any other state is ignored.
- R2: In Idle, `cpu_clk_en` is 0 while `per_clk_en`, `osc_en` and `fscm_en` stay 1.
- R3: Sleep entry lasts exactly one cycle and then leads to Sleep. In Sleep, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R4: `wdt_clr` is 1 only during the sleep-entry cycle, and only when `wdt_en` is 1. It is therefore issued before Sleep is reached.
- R5: `fscm_en` is 0 in Sleep and during oscillator restart, and 1 in every other state.
- R6: `lprc_en` is 1 whenever `wdt_en` is 1, and also when the oscillator runs with `osc_sel` equal to LPRC_SEL (default 5). In Sleep with `wdt_en`=0 it is 0.
- R7: A write through `sel_we`/`sel_wdata` updates `osc_sel` only in Run. This includes the cycle that carries a power-save request. Writes in any other state are ignored. On return from Sleep, `osc_sel` holds the value it had at entry.
- R8: A wake condition is any bit set in both `irq_pend` and `irq_en`, or `wdt_timeout`=1. A pending interrupt with its enable at 0 does not wake the block.
- R9: Idle with a wake condition goes to wake sync, then to Run on the following edge. Sleep with a wake condition goes to oscillator restart, where `osc_en`=1 and `per_clk_en`=0. It stays there until `osc_ready`=1 is sampled, then goes to wake sync and reaches Run one edge later.
- R10: `rst_n`=0 forces Run, `osc_sel`=RESET_SEL (default 0) and both status flags to 0, regardless of the current state.
- R11: `woke_sleep` or `woke_idle` is set on the edge that returns the block to Run, according to the mode that was left. Both flags are cleared when the next request is accepted.
- R12: A request accepted while a wake condition is already active still enters the selected mode, then leaves it by the normal wake path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous device reset, active low |
| pwr_req | input | 1 | Power-save request pulse |
| pwr_mode | input | 1 | Request operand: 0 Idle, 1 Sleep |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out event |
| osc_ready | input | 1 | Oscillator stable indication |
| sel_we | input | 1 | Clock selection write strobe |
| sel_wdata | input | SEL_W | Clock selection write value |
| pwr_state | output | 3 | Current state code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | System-clocked peripheral gate enable |
| osc_en | output | 1 | System clock source enable |
| fscm_en | output | 1 | Fail-safe clock monitor enable |
| lprc_en | output | 1 | Low-power RC clock enable |
| wdt_clr | output | 1 | Watchdog counter clear pulse |
| osc_sel | output | SEL_W | Active system clock selection |
| woke_sleep | output | 1 | Last return to Run was from Sleep |
| woke_idle | output | 1 | Last return to Run was from Idle |

## Verification
Two events can meet at one edge: a clock selection write and an accepted Sleep request. The bench raises both in the same cycle. It judges the case by reading `osc_sel` during Sleep and after wake, where the written value must survive the snapshot and reload. A request can also coincide with a wake condition that is already active. The bench holds an enabled interrupt high while it issues Idle and Sleep requests, and checks `pwr_state` edge by edge along the full entry-then-exit path.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_IDLE     = 3'd1,
      ST_ENTER    = 3'd2,
      ST_SLEEP    = 3'd3,
      ST_OSC_WAIT = 3'd4,
      ST_WAKE_SYN = 3'd5
   } lpm_state_e;

   localparam logic MODE_IDLE  = 1'b0;
   localparam logic MODE_SLEEP = 1'b1;

   typedef struct packed {
      logic cpu;
      logic per;
      logic osc;
      logic fscm;
   } gate_vec_t;

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
   parameter int N_IRQ = 8
) (
   input  logic [N_IRQ-1:0] irq_pend,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             wdt_timeout,
   output logic             wake
);

   initial begin
      if (N_IRQ < 1) $error("lpm_wake_detect: N_IRQ must be at least 1");
   end

   logic [N_IRQ-1:0] hit;

   for (genvar g = 0; g < N_IRQ; g++) begin : g_line
      assign hit[g] = irq_pend[g] & irq_en[g];
   end

   assign wake = (|hit) | wdt_timeout;

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_req,
   input  logic       pwr_mode,
   input  logic       wake,
   input  logic       osc_ready,
   output lpm_state_e state,
   output logic       in_run,
   output logic       snap,
   output logic       restore,
   output logic       woke_sleep,
   output logic       woke_idle
);

   lpm_state_e state_q, state_d;
   logic       accept;
   logic       left_sleep_q;

   assign accept = (state_q == ST_RUN) && pwr_req;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN: begin
            if (pwr_req) state_d = (pwr_mode == MODE_SLEEP) ? ST_ENTER : ST_IDLE;
         end
         ST_IDLE: begin
            if (wake) state_d = ST_WAKE_SYN;
         end
         ST_ENTER: begin
            state_d = ST_SLEEP;
         end
         ST_SLEEP: begin
            if (wake) state_d = ST_OSC_WAIT;
         end
         ST_OSC_WAIT: begin
            if (osc_ready) state_d = ST_WAKE_SYN;
         end
         ST_WAKE_SYN: begin
            state_d = ST_RUN;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_RUN;
         left_sleep_q <= 1'b0;
         woke_sleep   <= 1'b0;
         woke_idle    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            left_sleep_q <= (pwr_mode == MODE_SLEEP);
            woke_sleep   <= 1'b0;
            woke_idle    <= 1'b0;
         end else if (state_q == ST_WAKE_SYN) begin
            woke_sleep <= left_sleep_q;
            woke_idle  <= ~left_sleep_q;
         end
      end
   end

   assign state   = state_q;
   assign in_run  = (state_q == ST_RUN);
   assign snap    = (state_q == ST_ENTER);
   assign restore = (state_q == ST_WAKE_SYN) && left_sleep_q;

endmodule

// File: rtl/lpm_clk_sel.sv
module lpm_clk_sel #(
   parameter int              SEL_W     = 3,
   parameter logic [SEL_W-1:0] RESET_SEL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_run,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_data,
   input  logic             snap,
   input  logic             restore,
   output logic [SEL_W-1:0] sel
);

   initial begin
      if (SEL_W < 1) $error("lpm_clk_sel: SEL_W must be at least 1");
   end

   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] saved_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= RESET_SEL;
         saved_q <= RESET_SEL;
      end else begin
         if (restore)             sel_q <= saved_q;
         else if (wr_en && in_run) sel_q <= wr_data;
         if (snap) saved_q <= sel_q;
      end
   end

   assign sel = sel_q;

endmodule

// File: rtl/lpm_gate_decode.sv
module lpm_gate_decode
   import lpm_pkg::*;
#(
   parameter int              SEL_W    = 3,
   parameter logic [SEL_W-1:0] LPRC_SEL = 3'd5
) (
   input  lpm_state_e       state,
   input  logic             wdt_en,
   input  logic [SEL_W-1:0] sel,
   output gate_vec_t        gates,
   output logic             lprc_en,
   output logic             wdt_clr
);

   always_comb begin
      gates = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, fscm: 1'b1};
      unique case (state)
         ST_RUN:      gates = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, fscm: 1'b1};
         ST_IDLE:     gates = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, fscm: 1'b1};
         ST_ENTER:    gates = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, fscm: 1'b1};
         ST_SLEEP:    gates = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, fscm: 1'b0};
         ST_OSC_WAIT: gates = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, fscm: 1'b0};
         ST_WAKE_SYN: gates = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, fscm: 1'b1};
         default:     gates = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, fscm: 1'b1};
      endcase
   end

   assign lprc_en = wdt_en | (gates.osc && (sel == LPRC_SEL));
   assign wdt_clr = (state == ST_ENTER) && wdt_en;

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int              N_IRQ     = 8,
   parameter int              SEL_W     = 3,
   parameter logic [SEL_W-1:0] RESET_SEL = 3'd0,
   parameter logic [SEL_W-1:0] LPRC_SEL  = 3'd5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_req,
   input  logic             pwr_mode,
   input  logic [N_IRQ-1:0] irq_pend,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             wdt_en,
   input  logic             wdt_timeout,
   input  logic             osc_ready,
   input  logic             sel_we,
   input  logic [SEL_W-1:0] sel_wdata,
   output logic [2:0]       pwr_state,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             osc_en,
   output logic             fscm_en,
   output logic             lprc_en,
   output logic             wdt_clr,
   output logic [SEL_W-1:0] osc_sel,
   output logic             woke_sleep,
   output logic             woke_idle
);

   initial begin
      if (N_IRQ < 1)  $error("lpm_ctrl: N_IRQ must be at least 1");
      if (SEL_W < 1)  $error("lpm_ctrl: SEL_W must be at least 1");
      if (RESET_SEL == LPRC_SEL) $error("lpm_ctrl: reset selection must differ from the RC selection");
   end

   logic       wake;
   lpm_state_e state;
   logic       in_run, snap, restore;
   gate_vec_t  gates;

   lpm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
      .irq_pend    (irq_pend),
      .irq_en      (irq_en),
      .wdt_timeout (wdt_timeout),
      .wake        (wake)
   );

   lpm_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_req    (pwr_req),
      .pwr_mode   (pwr_mode),
      .wake       (wake),
      .osc_ready  (osc_ready),
      .state      (state),
      .in_run     (in_run),
      .snap       (snap),
      .restore    (restore),
      .woke_sleep (woke_sleep),
      .woke_idle  (woke_idle)
   );

   lpm_clk_sel #(.SEL_W(SEL_W), .RESET_SEL(RESET_SEL)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_run  (in_run),
      .wr_en   (sel_we),
      .wr_data (sel_wdata),
      .snap    (snap),
      .restore (restore),
      .sel     (osc_sel)
   );

   lpm_gate_decode #(.SEL_W(SEL_W), .LPRC_SEL(LPRC_SEL)) u_gate (
      .state   (state),
      .wdt_en  (wdt_en),
      .sel     (osc_sel),
      .gates   (gates),
      .lprc_en (lprc_en),
      .wdt_clr (wdt_clr)
   );

   assign pwr_state  = state;
   assign cpu_clk_en = gates.cpu;
   assign per_clk_en = gates.per;
   assign osc_en     = gates.osc;
   assign fscm_en    = gates.fscm;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       pwr_state,
   input logic             cpu_clk_en,
   input logic             per_clk_en,
   input logic             osc_en,
   input logic             fscm_en,
   input logic             lprc_en,
   input logic             wdt_clr,
   input logic             wdt_en,
   input logic             osc_ready,
   input logic [SEL_W-1:0] osc_sel,
   input logic             woke_sleep,
   input logic             woke_idle
);

   p_idle_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd1) |-> (!cpu_clk_en && per_clk_en && osc_en));

   p_sleep_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd3) |-> (!cpu_clk_en && !per_clk_en && !osc_en));

   p_entry_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd2) |=> (pwr_state == 3'd3));

   p_wdt_clr_before_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd3 && $past(pwr_state) == 3'd2) |-> ($past(wdt_clr) == $past(wdt_en)));

   p_monitor_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!per_clk_en) |-> (!fscm_en));

   p_rc_with_wdt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_en |-> lprc_en);

   p_sel_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state != 3'd0 && $past(pwr_state) != 3'd0) |-> $stable(osc_sel));

   p_osc_ready_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd4 && osc_ready) |=> (pwr_state == 3'd5));

   p_sync_to_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd5) |=> (pwr_state == 3'd0 && cpu_clk_en));

   p_status_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({woke_sleep, woke_idle}));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_state  (pwr_state),
   .cpu_clk_en (cpu_clk_en),
   .per_clk_en (per_clk_en),
   .osc_en     (osc_en),
   .fscm_en    (fscm_en),
   .lprc_en    (lprc_en),
   .wdt_clr    (wdt_clr),
   .wdt_en     (wdt_en),
   .osc_ready  (osc_ready),
   .osc_sel    (osc_sel),
   .woke_sleep (woke_sleep),
   .woke_idle  (woke_idle)
);

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;

   localparam int N_IRQ = 8;
   localparam int SEL_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pwr_req = 1'b0;
   logic             pwr_mode = 1'b0;
   logic [N_IRQ-1:0] irq_pend = '0;
   logic [N_IRQ-1:0] irq_en = '0;
   logic             wdt_en = 1'b0;
   logic             wdt_timeout = 1'b0;
   logic             osc_ready = 1'b1;
   logic             sel_we = 1'b0;
   logic [SEL_W-1:0] sel_wdata = '0;
   logic [2:0]       pwr_state;
   logic             cpu_clk_en, per_clk_en, osc_en, fscm_en, lprc_en, wdt_clr;
   logic [SEL_W-1:0] osc_sel;
   logic             woke_sleep, woke_idle;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   lpm_ctrl #(.N_IRQ(N_IRQ), .SEL_W(SEL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .pwr_mode(pwr_mode),
      .irq_pend(irq_pend), .irq_en(irq_en), .wdt_en(wdt_en),
      .wdt_timeout(wdt_timeout), .osc_ready(osc_ready), .sel_we(sel_we),
      .sel_wdata(sel_wdata), .pwr_state(pwr_state), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .osc_en(osc_en), .fscm_en(fscm_en),
      .lprc_en(lprc_en), .wdt_clr(wdt_clr), .osc_sel(osc_sel),
      .woke_sleep(woke_sleep), .woke_idle(woke_idle)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_err = n_err + 1;
         $display("FAIL watchdog: run did not finish, act=%0d cycles exp<=100000", cyc);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_err = n_err + 1;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic request(input logic mode);
      pwr_req  = 1'b1;
      pwr_mode = mode;
      step();
      pwr_req  = 1'b0;
   endtask

   task automatic t_reset_state;
      chk("R10", "state", pwr_state, 0);
      chk("R10", "osc_sel", osc_sel, 0);
      chk("R10", "status", {woke_sleep, woke_idle}, 0);
      chk("R5", "run gates cpu/per/osc/fscm", {cpu_clk_en, per_clk_en, osc_en, fscm_en}, 4'hF);
      chk("R6", "rc off without watchdog", lprc_en, 0);
   endtask

   task automatic t_idle_cycle;
      request(1'b0);
      chk("R1", "idle state", pwr_state, 1);
      chk("R2", "idle gates cpu/per/osc/fscm", {cpu_clk_en, per_clk_en, osc_en, fscm_en}, 4'h7);
      pwr_req = 1'b1; pwr_mode = 1'b1;
      step();
      pwr_req = 1'b0;
      chk("R1", "request ignored in idle", pwr_state, 1);
      irq_pend = 8'h01; irq_en = 8'h01;
      step();
      chk("R9", "idle wake sync", pwr_state, 5);
      chk("R9", "sync cpu still gated", cpu_clk_en, 0);
      step();
      chk("R9", "idle back to run", pwr_state, 0);
      chk("R11", "woke_idle/woke_sleep", {woke_idle, woke_sleep}, 2'b10);
      irq_pend = '0; irq_en = '0;
   endtask

   task automatic t_sleep_cycle(input logic wd);
      wdt_en = wd;
      osc_ready = 1'b0;
      request(1'b1);
      chk("R11", "status cleared on accept", {woke_sleep, woke_idle}, 0);
      chk("R3", "entry state", pwr_state, 2);
      chk("R4", "watchdog clear in entry", wdt_clr, wd);
      chk("R3", "entry cpu/osc", {cpu_clk_en, osc_en}, 2'b01);
      step();
      chk("R3", "sleep state", pwr_state, 3);
      chk("R3", "sleep cpu/per/osc", {cpu_clk_en, per_clk_en, osc_en}, 3'b000);
      chk("R4", "no clear in sleep", wdt_clr, 0);
      chk("R5", "monitor off in sleep", fscm_en, 0);
      chk("R6", "rc follows watchdog", lprc_en, wd);
      irq_pend = 8'hF0; irq_en = 8'h0F;
      step(3);
      chk("R8", "masked pending does not wake", pwr_state, 3);
      irq_pend = 8'h08; irq_en = 8'h08;
      step();
      chk("R9", "oscillator restart", pwr_state, 4);
      chk("R9", "restart osc/per", {osc_en, per_clk_en}, 2'b10);
      chk("R5", "monitor off in restart", fscm_en, 0);
      step(2);
      chk("R9", "waits for osc_ready", pwr_state, 4);
      osc_ready = 1'b1;
      step();
      chk("R9", "sync after ready", pwr_state, 5);
      chk("R5", "monitor back on", fscm_en, 1);
      step();
      chk("R9", "run after sync", pwr_state, 0);
      chk("R11", "woke_sleep/woke_idle", {woke_sleep, woke_idle}, 2'b10);
      irq_pend = '0; irq_en = '0;
      wdt_en = 1'b0;
   endtask

   task automatic t_sel_rules;
      sel_we = 1'b1; sel_wdata = 3'd6;
      request(1'b1);
      sel_we = 1'b0;
      chk("R7", "write with request applied", osc_sel, 6);
      osc_ready = 1'b0;
      step();
      sel_we = 1'b1; sel_wdata = 3'd3;
      step();
      sel_we = 1'b0;
      chk("R7", "write in sleep ignored", osc_sel, 6);
      wdt_timeout = 1'b1;
      step();
      wdt_timeout = 1'b0;
      chk("R8", "watchdog timeout wakes", pwr_state, 4);
      osc_ready = 1'b1;
      step(2);
      chk("R7", "selection after wake", osc_sel, 6);
      chk("R7", "back in run", pwr_state, 0);
   endtask

   task automatic t_rc_selected;
      sel_we = 1'b1; sel_wdata = 3'd5;
      step();
      sel_we = 1'b0;
      chk("R6", "rc runs as system source", lprc_en, 1);
      osc_ready = 1'b0;
      request(1'b1);
      step();
      chk("R6", "rc stops in sleep without watchdog", lprc_en, 0);
      wdt_timeout = 1'b1; osc_ready = 1'b1;
      step();
      wdt_timeout = 1'b0;
      step(2);
      chk("R6", "rc back after wake", lprc_en, 1);
   endtask

   task automatic t_reset_in_sleep;
      sel_we = 1'b1; sel_wdata = 3'd2;
      step();
      sel_we = 1'b0;
      request(1'b1);
      step();
      chk("R10", "in sleep before reset", pwr_state, 3);
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      step();
      chk("R10", "state after reset", pwr_state, 0);
      chk("R10", "reset selection", osc_sel, 0);
      chk("R10", "cpu clock after reset", cpu_clk_en, 1);
   endtask

   task automatic t_req_with_wake;
      irq_pend = 8'h80; irq_en = 8'h80;
      step();
      chk("R12", "wake ignored in run", pwr_state, 0);
      request(1'b0);
      chk("R12", "idle entered despite wake", pwr_state, 1);
      step();
      chk("R12", "idle sync", pwr_state, 5);
      step();
      chk("R12", "idle exit", pwr_state, 0);
      request(1'b1);
      chk("R12", "sleep entry despite wake", pwr_state, 2);
      step();
      chk("R12", "sleep reached", pwr_state, 3);
      step();
      chk("R12", "restart", pwr_state, 4);
      step();
      chk("R12", "sync", pwr_state, 5);
      step();
      chk("R12", "run", pwr_state, 0);
      irq_pend = '0; irq_en = '0;
   endtask

   initial begin
      step(2);
      rst_n = 1'b1;
      step();
      t_reset_state();
      t_idle_cycle();
      t_sleep_cycle(1'b1);
      t_sleep_cycle(1'b0);
      t_sel_rules();
      t_rc_selected();
      t_reset_in_sleep();
      t_req_with_wake();
      step(2);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule